// File: doc/BRIEF.md
# Receiver-Detect Control State Machine

This block decides when a serial link output sends a probe toward the far end to find a receiver, and how the local input termination is set while it does so. A free-running clock feeds a microsecond tick prescaler. All intervals are counted in those ticks: the probe period, the length of the probing window and the power-down reset qualification. A simulation can therefore scale milliseconds down to a few cycles by changing one frequency parameter.

A 2-bit mode input picks one of four behaviours. In mode 00 and mode 11 the block does not probe; the termination is fixed at high impedance in mode 00 and at 50 ohm in mode 11. In mode 01 the block probes periodically over a bounded window and then gives up. In mode 10 it probes periodically until a receiver is found. The analog detector answers each probe on a level input. A found receiver switches the termination to 50 ohm and is held until the machine restarts. There are four restart sources: reset release, a power-down held long enough, a software toggle of a presence bit while an override bit is set, and a change of mode.

Top module: `rx_detect_ctrl`

## Requirements
- R1: With mode_i = 2'b00 the termination is high impedance (term_50_o = 0), probe_o stays low and detected_o stays 0.
- R2: With mode_i = 2'b01 a one-cycle probe_o pulse is issued every PROBE_PERIOD_US microseconds. After PROBE_SLOTS probes that all find rx_present_i low, probing stops until the next restart.
- R3: With mode_i = 2'b10 a one-cycle probe_o pulse is issued every PROBE_PERIOD_US microseconds with no limit, until a probe finds a receiver.
- R4: With mode_i = 2'b11 and no power-down, term_50_o = 1 and probe_o stays low.
- R5: In modes 01 and 10, term_50_o is 0 until a probe samples rx_present_i high in the probe_o cycle. From then on detected_o = 1 and term_50_o = 1, and no further probe is sent until a restart.
- R6: While pwdn_i = 1, term_50_o = 0, drv_en_o = 0 and probe_o = 0 in every mode. The state machine is frozen.
- R7: pwdn_i held high for at least PWDN_RESET_US microseconds (PWDN_RESET_US·CLK_FREQ_HZ/1e6 clock edges) restarts the machine. A shorter pulse leaves the detected state untouched.
- R8: While sw_override_i = 1, any change of sw_present_i restarts the machine. With sw_override_i = 0 a change of sw_present_i has no effect, and setting sw_override_i alone has no effect.
- R9: Any change of mode_i restarts the machine in the initial state of the new mode.
- R10: A restart wins over a probe in the same cycle. probe_o is suppressed, that probe's result is discarded, and the next probe comes one full period after the restart edge.
- R11: After rst_ni is released the first clock edge is a restart. With one clock per microsecond, the first probe appears on the (PROBE_PERIOD_US+1)-th clock after release. During reset all outputs except drv_en_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Detect mode select |
| pwdn_i | input | 1 | Power-down request |
| rx_present_i | input | 1 | Detector answer, sampled in the probe_o cycle |
| sw_override_i | input | 1 | Software override enable for the presence bit |
| sw_present_i | input | 1 | Software presence bit; a change restarts when overridden |
| probe_o | output | 1 | One-cycle probe strobe toward the output stage |
| term_50_o | output | 1 | Input termination: 1 = 50 ohm, 0 = high impedance |
| drv_en_o | output | 1 | Output driver enable |
| detected_o | output | 1 | Receiver detected |

## Verification
A restart and a probe can fall on the same clock edge. In that case the probe result must be dropped and the period counter must start again from zero. The bench waits until probe_o is seen high with rx_present_i = 1, and at that moment toggles sw_present_i with the override set. It then expects detected_o to stay 0 after that edge and the next probe to arrive exactly one period plus one cycle later, at which point the detection completes.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [1:0] {
    MODE_MAN_HIZ  = 2'b00,
    MODE_AUTO_WIN = 2'b01,
    MODE_AUTO_INF = 2'b10,
    MODE_MAN_TERM = 2'b11
  } rxd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_FOUND,
    ST_EXPIRED
  } rxd_state_e;

  function automatic logic mode_is_auto(input logic [1:0] m);
    return m[1] ^ m[0];
  endfunction
endpackage

// File: rtl/rxd_us_tick.sv
module rxd_us_tick #(
  parameter int unsigned CYC_PER_US = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (CYC_PER_US <= 1) begin : g_direct
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned DW = $clog2(CYC_PER_US);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else if (div_q == DW'(CYC_PER_US - 1)) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == DW'(CYC_PER_US - 1));
    end
  endgenerate
endmodule

// File: rtl/rxd_restart_ctl.sv
module rxd_restart_ctl #(
  parameter int unsigned PWDN_RST_CYC = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       pwdn_i,
  input  logic       sw_override_i,
  input  logic       sw_present_i,
  output logic       restart_o
);
  localparam int unsigned CW = $clog2(PWDN_RST_CYC + 1);

  logic [CW-1:0] pw_cnt_q;
  logic          init_q;
  logic          pres_q;
  logic [1:0]    mode_q;
  logic          pwdn_fire, soft_fire, mode_fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pw_cnt_q <= '0;
      init_q   <= 1'b1;
      pres_q   <= 1'b0;
      mode_q   <= 2'b00;
    end else begin
      init_q <= 1'b0;
      pres_q <= sw_present_i;
      mode_q <= mode_i;
      if (!pwdn_i) pw_cnt_q <= '0;
      else if (pw_cnt_q != CW'(PWDN_RST_CYC)) pw_cnt_q <= pw_cnt_q + 1'b1;
    end
  end

  // fires once, on the qualifying edge of a long enough power-down
  assign pwdn_fire = pwdn_i && (pw_cnt_q == CW'(PWDN_RST_CYC - 1));
  assign soft_fire = sw_override_i && (sw_present_i != pres_q);
  assign mode_fire = (mode_i != mode_q);
  assign restart_o = init_q | pwdn_fire | soft_fire | mode_fire;
endmodule

// File: rtl/rxd_probe_fsm.sv
module rxd_probe_fsm
  import rxd_pkg::*;
#(
  parameter int unsigned PROBE_PERIOD_US = 12000,
  parameter int unsigned PROBE_SLOTS     = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       hold_i,
  input  logic       restart_i,
  input  logic [1:0] mode_i,
  input  logic       rx_present_i,
  output logic       probe_q_o,
  output rxd_state_e state_o
);
  localparam int unsigned UW = $clog2(PROBE_PERIOD_US);
  localparam int unsigned SW = $clog2(PROBE_SLOTS);

  rxd_state_e    state_q;
  logic [UW-1:0] us_cnt_q;
  logic [SW-1:0] slot_q;
  logic          probe_q;
  logic          wrap;

  assign wrap = tick_i && (us_cnt_q == UW'(PROBE_PERIOD_US - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      us_cnt_q <= '0;
      slot_q   <= '0;
      probe_q  <= 1'b0;
    end else if (restart_i) begin
      state_q  <= mode_is_auto(mode_i) ? ST_SEARCH : ST_IDLE;
      us_cnt_q <= '0;
      slot_q   <= '0;
      probe_q  <= 1'b0;
    end else if (!hold_i) begin
      probe_q <= 1'b0;
      if (state_q == ST_SEARCH) begin
        if (tick_i) us_cnt_q <= wrap ? '0 : us_cnt_q + 1'b1;
        if (probe_q) begin
          if (rx_present_i) begin
            state_q <= ST_FOUND;
          end else if (mode_i == MODE_AUTO_WIN &&
                       slot_q == SW'(PROBE_SLOTS - 1)) begin
            state_q <= ST_EXPIRED;
          end else begin
            slot_q <= slot_q + 1'b1;
            probe_q <= wrap;
          end
        end else begin
          probe_q <= wrap;
        end
      end
    end
  end

  assign probe_q_o = probe_q;
  assign state_o   = state_q;
endmodule

// File: rtl/rx_detect_ctrl.sv
module rx_detect_ctrl
  import rxd_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ     = 100_000_000,
  parameter int unsigned PROBE_PERIOD_US = 12_000,
  parameter int unsigned PROBE_SLOTS     = 50,
  parameter int unsigned PWDN_RESET_US   = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       pwdn_i,
  input  logic       rx_present_i,
  input  logic       sw_override_i,
  input  logic       sw_present_i,
  output logic       probe_o,
  output logic       term_50_o,
  output logic       drv_en_o,
  output logic       detected_o
);
  localparam int unsigned CYC_PER_US   = CLK_FREQ_HZ / 1_000_000;
  localparam int unsigned PWDN_RST_CYC = PWDN_RESET_US * CYC_PER_US;

  logic       tick;
  logic       restart;
  logic       probe_q;
  rxd_state_e state;
  logic       found;

  rxd_us_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  rxd_restart_ctl #(.PWDN_RST_CYC(PWDN_RST_CYC)) u_restart (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode_i),
    .pwdn_i       (pwdn_i),
    .sw_override_i(sw_override_i),
    .sw_present_i (sw_present_i),
    .restart_o    (restart)
  );

  rxd_probe_fsm #(
    .PROBE_PERIOD_US(PROBE_PERIOD_US),
    .PROBE_SLOTS    (PROBE_SLOTS)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .hold_i      (pwdn_i),
    .restart_i   (restart),
    .mode_i      (mode_i),
    .rx_present_i(rx_present_i),
    .probe_q_o   (probe_q),
    .state_o     (state)
  );

  // a pending restart masks stale state in the same cycle
  assign found      = (state == ST_FOUND) && !restart;
  assign probe_o    = probe_q && !pwdn_i && !restart;
  assign detected_o = found;
  assign drv_en_o   = !pwdn_i;
  assign term_50_o  = !pwdn_i &&
                      ((mode_i == MODE_MAN_TERM) || (mode_is_auto(mode_i) && found));
endmodule

// File: rtl/rxd_ctrl_chk.sv
module rxd_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       pwdn_i,
  input logic       probe_o,
  input logic       term_50_o,
  input logic       drv_en_o,
  input logic       detected_o
);
  AST_MAN_HIZ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |-> (!term_50_o && !probe_o && !detected_o)); // R1
  AST_PROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_o |=> !probe_o); // R3
  AST_MAN_TERM_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && !pwdn_i) |-> (term_50_o && !probe_o)); // R4
  AST_FOUND_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (detected_o && !pwdn_i) |-> term_50_o); // R5
  AST_FOUND_NO_PROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detected_o |-> !probe_o); // R5
  AST_PWDN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwdn_i |-> (!drv_en_o && !term_50_o && !probe_o)); // R6
endmodule

bind rx_detect_ctrl rxd_ctrl_chk u_chk (.*);

// File: tb/rx_detect_ctrl_bench.sv
module rx_detect_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P     = 10;
  localparam int SLOTS = 50;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [1:0] mode_i;
  logic       pwdn_i, rx_present_i, sw_override_i, sw_present_i;
  logic       probe_o, term_50_o, drv_en_o, detected_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rx_detect_ctrl #(
    .CLK_FREQ_HZ(1_000_000), .PROBE_PERIOD_US(P),
    .PROBE_SLOTS(SLOTS), .PWDN_RESET_US(5)
  ) u_rx_detect_ctrl (.*);

  typedef struct packed {
    logic [1:0] mode;
    logic       rx;
    int         win;
    int         probes;
    logic       term;
    logic       det;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'b00, 1'b0, 100, 0,  1'b0, 1'b0},   // R1
    '{2'b11, 1'b1, 100, 0,  1'b1, 1'b0},   // R4
    '{2'b10, 1'b0, 600, 60, 1'b0, 1'b0},   // R3
    '{2'b10, 1'b1, 100, 1,  1'b1, 1'b1},   // R5
    '{2'b01, 1'b0, 600, SLOTS, 1'b0, 1'b0},// R2
    '{2'b01, 1'b1, 100, 1,  1'b1, 1'b1}    // R5
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_probe(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!probe_o && n < 1000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    rst_ni = 1'b0; mode_i = 2'b10; pwdn_i = 1'b0; rx_present_i = 1'b0;
    sw_override_i = 1'b0; sw_present_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(!probe_o && !term_50_o && !detected_o && drv_en_o, "R11 reset outputs",
          {probe_o, term_50_o, detected_o, drv_en_o}, 4'b0001);
    rst_ni = 1'b1;
    wait_probe(n);
    check(n == P + 1, "R11 first probe delay", n, P + 1);

    foreach (VEC[i]) begin
      int cnt;
      @(negedge clk_i);
      mode_i = VEC[i].mode; rx_present_i = VEC[i].rx; pwdn_i = 1'b1;
      repeat (6) @(negedge clk_i);
      pwdn_i = 1'b0;
      cnt = 0;
      for (int j = 0; j < VEC[i].win; j++) begin
        @(negedge clk_i);
        if (probe_o) cnt++;
      end
      check(cnt == VEC[i].probes, $sformatf("R2/R3 vec%0d probe count", i), cnt, VEC[i].probes);
      check(term_50_o == VEC[i].term, $sformatf("R1 R4 R5 vec%0d term", i), term_50_o, VEC[i].term);
      check(detected_o == VEC[i].det, $sformatf("R5 vec%0d detected", i), detected_o, VEC[i].det);
      check(drv_en_o == 1'b1, $sformatf("R6 vec%0d drv_en", i), drv_en_o, 1);
    end

    // R6 / R7: short power-down keeps detection
    mode_i = 2'b10; rx_present_i = 1'b1;
    repeat (3 * P) @(negedge clk_i);
    check(detected_o == 1'b1, "R5 detected before pwdn", detected_o, 1);
    pwdn_i = 1'b1;
    repeat (4) begin
      @(negedge clk_i);
      check(!term_50_o && !drv_en_o && !probe_o, "R6 pwdn forces off",
            {term_50_o, drv_en_o, probe_o}, 0);
    end
    pwdn_i = 1'b0;
    @(negedge clk_i);
    check(detected_o && term_50_o, "R7 short pwdn no reset", {detected_o, term_50_o}, 3);

    // R7: qualified power-down resets
    pwdn_i = 1'b1;
    repeat (5) @(negedge clk_i);
    pwdn_i = 1'b0; rx_present_i = 1'b0;
    @(negedge clk_i);
    check(!detected_o && !term_50_o, "R7 long pwdn resets", {detected_o, term_50_o}, 0);

    // R8: software restart
    rx_present_i = 1'b1;
    repeat (P + 2) @(negedge clk_i);
    check(detected_o == 1'b1, "R8 detected before soft reset", detected_o, 1);
    rx_present_i = 1'b0;
    sw_present_i = ~sw_present_i;
    @(negedge clk_i);
    check(detected_o == 1'b1, "R8 toggle without override ignored", detected_o, 1);
    sw_override_i = 1'b1;
    @(negedge clk_i);
    check(detected_o == 1'b1, "R8 override alone ignored", detected_o, 1);
    sw_present_i = ~sw_present_i;
    @(negedge clk_i);
    check(detected_o == 1'b0, "R8 override toggle resets", detected_o, 0);

    // R9: mode change restarts
    rx_present_i = 1'b1;
    repeat (P + 2) @(negedge clk_i);
    check(detected_o == 1'b1, "R9 detected before mode change", detected_o, 1);
    mode_i = 2'b01;
    @(negedge clk_i);
    check(!detected_o && !term_50_o, "R9 mode change restarts", {detected_o, term_50_o}, 0);

    // R10: restart on the probe edge
    mode_i = 2'b10; rx_present_i = 1'b1;
    wait_probe(n);
    sw_present_i = ~sw_present_i;
    @(negedge clk_i);
    check(detected_o == 1'b0, "R10 restart beats probe", detected_o, 0);
    n = 1;
    while (!probe_o && n < 1000) begin
      @(negedge clk_i);
      n++;
    end
    check(n == P + 1, "R10 next probe after restart", n, P + 1);
    @(negedge clk_i);
    check(detected_o == 1'b1, "R10 later probe detects", detected_o, 1);

    finish_run();
  end
endmodule